// File: doc/BRIEF.md
# Pipelined Burst SRAM with Fixed-Delay Data Phases

This block is a cycle model of a synchronous, pipelined static RAM. It can be built into logic. Every enabled clock edge can take a new read or write command, in any mix and with no idle cycle at a read/write change. The design makes this possible by placing the data phase of every command a fixed two enabled edges after the command edge, for reads and writes alike. Because of that, two data phases can never compete for the bus.

A word is 36 bits wide and is made of four 9-bit lanes (8 data bits plus 1 parity bit each). One load command carries an address, and up to three advance commands then extend it into a burst of four beats. An internal 2-bit counter generates the beat addresses, in either linear or interleaved order.

The data bus is split into an input half and an output half with a drive-enable, so that the tri-state pad sits outside the block. The bus has no valid/ready handshake. The data phase has a fixed latency, and the only form of back-pressure is `clk_en`: when it is low, the whole pipeline freezes for that cycle.

Top module: `pipe_burst_sram`

## Requirements
- R1: A read command sampled at enabled edge N puts its word on `dq_o` with `dq_drive` high during the cycle that ends at enabled edge N+2. The word stays there until that edge.
- R2: For a write command sampled at enabled edge N, `dq_i` is sampled at enabled edge N+2. Lane k is bits [9k+8:9k]. Only the lanes whose `lane_we` bit was 1 at the command edge are written, and any mix of lanes is allowed.
- R3: Reads and writes can alternate on every enabled edge. A read always returns the most recent data in command order, including the lanes of a write whose data is still in flight, merged lane by lane.
- R4: With `adv`=0 and `sel`=1, a new address is loaded and beat 0 of a burst starts. With `adv`=1, the next beat of the same command type is issued, whatever `sel`, `wr` and `addr` are, up to four beats in total. An advance after the fourth beat, or with no burst open, is a no-operation.
- R5: In linear order, beat c uses the address bits above bit 1 unchanged, and uses (base[1:0]+c) mod 4 as the low two bits, so the burst wraps inside the aligned group of four.
- R6: When `burst_ilv`=1 at the load edge, beat c uses base[1:0] XOR c as the low two bits.
- R7: While `clk_en`=0, no command is taken, no write is done, and `dq_o` and `dq_drive` hold their values. A burst that was stalled resumes where it stopped.
- R8: With `adv`=0 and `sel`=0, the command is a deselect. It makes no access, closes any open burst, and leaves `dq_drive` low once earlier data phases have finished.
- R9: `dq_drive` is high only in a read data phase while `out_en`=1. Setting `out_en` to 0 has no effect on the pipeline or on memory.
- R10: A no-operation leaves memory unchanged and drives no data.
- R11: After reset, `dq_drive` is 0, no burst is open and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | 1 = edge is active, 0 = stall the whole pipeline |
| sel | input | 1 | Chip select, used on load cycles |
| adv | input | 1 | 0 = load new command, 1 = advance burst |
| wr | input | 1 | 1 = write, 0 = read, used on load cycles |
| lane_we | input | 4 | Per-lane write enables for a write beat |
| burst_ilv | input | 1 | Burst order chosen at load: 0 linear, 1 interleaved |
| addr | input | 6 | Word address for load cycles |
| out_en | input | 1 | Output-driver enable |
| dq_i | input | 36 | Write data from the bus pad |
| dq_o | output | 36 | Read data toward the bus pad |
| dq_drive | output | 1 | Pad drive enable; 0 means high impedance |

## Verification
On every cycle, the assertions check how the command sequencer reacts to advance, deselect and no-burst cases. They also check that a stall freezes the output stage and that read and write data phases never overlap. Only the bench's scenarios can show that data is correct end to end. This covers per-lane merging of in-flight writes into following reads, linear and interleaved wrap order, bursts resumed after mid-burst stalls, and the absence of writes from no-operations and from beats after a deselect. It also covers the exact cycle in which each read word reaches the bus.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/pbs_cmd_seq.sv
// Command decode and burst address generation; registers the stage-1 command.
module pbs_cmd_seq #(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             sel,
  input  logic             adv,
  input  logic             wr,
  input  logic [LANES-1:0] lane_we,
  input  logic             burst_ilv,
  input  logic [AW-1:0]    addr,
  output pbs_pkg::op_e     s1_op,
  output logic [AW-1:0]    s1_addr,
  output logic [LANES-1:0] s1_lanes
);
  import pbs_pkg::*;

  logic          act;
  logic [1:0]    cnt;
  logic [AW-1:0] base;
  logic          ilv_q;
  op_e           last_op;
  logic [1:0]    nxt_cnt;
  logic [1:0]    beat_lo;

  always_comb begin
    nxt_cnt = cnt + 2'd1;
    beat_lo = ilv_q ? (base[1:0] ^ nxt_cnt) : (base[1:0] + nxt_cnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act      <= 1'b0;
      cnt      <= 2'd0;
      base     <= '0;
      ilv_q    <= 1'b0;
      last_op  <= OP_IDLE;
      s1_op    <= OP_IDLE;
      s1_addr  <= '0;
      s1_lanes <= '0;
    end else if (clk_en) begin
      if (!adv) begin
        if (sel) begin
          act      <= 1'b1;
          cnt      <= 2'd0;
          base     <= addr;
          ilv_q    <= burst_ilv;
          last_op  <= wr ? OP_WRITE : OP_READ;
          s1_op    <= wr ? OP_WRITE : OP_READ;
          s1_addr  <= addr;
          s1_lanes <= wr ? lane_we : '0;
        end else begin
          act      <= 1'b0;
          s1_op    <= OP_IDLE;
          s1_lanes <= '0;
        end
      end else if (act) begin
        cnt      <= nxt_cnt;
        act      <= (nxt_cnt != 2'd3);
        s1_op    <= last_op;
        s1_addr  <= {base[AW-1:2], beat_lo};
        s1_lanes <= (last_op == OP_WRITE) ? lane_we : '0;
      end else begin
        s1_op    <= OP_IDLE;
        s1_lanes <= '0;
      end
    end
  end

  // R4: advance with no open burst issues nothing
  a_r4_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv && !act) |=> (s1_op == OP_IDLE));

  // R4: each advance moves the beat counter by one
  a_r4_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv && act) |=> (cnt == $past(cnt) + 2'd1));

  // R8: deselect issues nothing and closes the burst
  a_r8_deselect_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !adv && !sel) |=> (s1_op == OP_IDLE && !act));

  // R5: burst beats stay inside the aligned group of four
  a_r5_group_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && adv && act) |=> (s1_addr[AW-1:2] == $past(base[AW-1:2])));

  // R7: stalled edge leaves the command stage untouched
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(s1_op) && $stable(cnt) && $stable(act)));
endmodule

// File: rtl/pbs_store.sv
// Lane-split storage: one write port with lane mask, one asynchronous read port.
module pbs_store #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] wmask,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[g]) lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
  end
endmodule

// File: rtl/pipe_burst_sram.sv
// Top: command stage, data-phase stage with in-flight write bypass, output stage.
module pipe_burst_sram #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             sel,
  input  logic             adv,
  input  logic             wr,
  input  logic [LANES-1:0] lane_we,
  input  logic             burst_ilv,
  input  logic [AW-1:0]    addr,
  input  logic             out_en,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_drive
);
  import pbs_pkg::*;

  op_e              s1_op;
  logic [AW-1:0]    s1_addr;
  logic [LANES-1:0] s1_lanes;

  logic             ph_wr_v;
  logic [AW-1:0]    ph_wr_addr;
  logic [LANES-1:0] ph_wr_lanes;
  logic             rd_valid_q;
  logic [DW-1:0]    dout_q;
  logic [DW-1:0]    rd_word;
  logic [DW-1:0]    merged;
  logic             hit;

  pbs_cmd_seq #(.AW(AW), .LANES(LANES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .sel      (sel),
    .adv      (adv),
    .wr       (wr),
    .lane_we  (lane_we),
    .burst_ilv(burst_ilv),
    .addr     (addr),
    .s1_op    (s1_op),
    .s1_addr  (s1_addr),
    .s1_lanes (s1_lanes)
  );

  // Write commits on the edge that samples its data from the bus.
  pbs_store #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk  (clk),
    .we   (clk_en && ph_wr_v),
    .waddr(ph_wr_addr),
    .wmask(ph_wr_lanes),
    .wdata(dq_i),
    .raddr(s1_addr),
    .rdata(rd_word)
  );

  // A read one edge behind a write to the same word takes the lanes from the bus.
  always_comb begin
    hit = ph_wr_v && (ph_wr_addr == s1_addr);
    for (int l = 0; l < LANES; l++) begin
      merged[l*LANE_W +: LANE_W] = (hit && ph_wr_lanes[l]) ? dq_i[l*LANE_W +: LANE_W]
                                                           : rd_word[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_wr_v     <= 1'b0;
      ph_wr_addr  <= '0;
      ph_wr_lanes <= '0;
      rd_valid_q  <= 1'b0;
      dout_q      <= '0;
    end else if (clk_en) begin
      ph_wr_v     <= (s1_op == OP_WRITE);
      ph_wr_addr  <= s1_addr;
      ph_wr_lanes <= s1_lanes;
      rd_valid_q  <= (s1_op == OP_READ);
      if (s1_op == OP_READ) dout_q <= merged;
    end
  end

  assign dq_o     = dout_q;
  assign dq_drive = rd_valid_q && out_en;

  // R7: a stalled edge freezes the data-phase stage and output
  a_r7_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(dout_q) && $stable(rd_valid_q) && $stable(ph_wr_v)));

  // R9: a read data phase and a write data phase never share a cycle
  a_r9_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid_q && ph_wr_v));

  // R1: output word changes only on an enabled edge that completes a read
  a_r1_output_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_en && s1_op == OP_READ) |=> $stable(dout_q));

  // R11: nothing is driven or pending right after reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!rd_valid_q && !ph_wr_v));
endmodule

// File: tb/pipe_burst_sram_test.sv
module pipe_burst_sram_test;
  localparam int DEPTH = 64, LANES = 4, LANE_W = 9;
  localparam int AW = 6, DW = 36;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clk_en = 1'b0, sel = 1'b0, adv = 1'b0, wr = 1'b0;
  logic             out_en = 1'b1, burst_ilv = 1'b0;
  logic [LANES-1:0] lane_we = '0;
  logic [AW-1:0]    addr = '0;
  logic [DW-1:0]    dq_i;
  logic [DW-1:0]    dq_o;
  logic             dq_drive;

  pipe_burst_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel(sel), .adv(adv), .wr(wr),
    .lane_we(lane_we), .burst_ilv(burst_ilv), .addr(addr), .out_en(out_en),
    .dq_i(dq_i), .dq_o(dq_o), .dq_drive(dq_drive)
  );

  always #2 clk = ~clk;

  typedef struct {
    int          due;
    logic [DW-1:0] data;
    string       req;
  } item_t;

  item_t         rq[$];
  item_t         wq[$];
  logic [DW-1:0] ref_mem [DEPTH];
  int            checks = 0, fails = 0, n_en = 0;
  bit            done = 0;

  bit            b_act = 0, b_ilv = 0, b_wr = 0;
  int            b_cnt = 0;
  logic [AW-1:0] b_base = '0;

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard push: expected data phase lands on enabled edge idx+2.
  task automatic push_cmd(bit is_wr, logic [AW-1:0] a, logic [LANES-1:0] lanes, string req);
    item_t it;
    logic [63:0] r;
    it.due = n_en + 1 + 2;
    it.req = req;
    if (is_wr) begin
      r = {$urandom, $urandom};
      it.data = r[DW-1:0];
      wq.push_back(it);
      for (int l = 0; l < LANES; l++)
        if (lanes[l]) ref_mem[a][l*LANE_W +: LANE_W] = it.data[l*LANE_W +: LANE_W];
    end else begin
      it.data = ref_mem[a];
      rq.push_back(it);
    end
  endtask

  task automatic t_load(bit w, logic [AW-1:0] a, logic [LANES-1:0] lanes, bit ilv, string req);
    @(negedge clk);
    clk_en = 1; sel = 1; adv = 0; wr = w; addr = a; lane_we = lanes; burst_ilv = ilv;
    push_cmd(w, a, lanes, req);
    b_act = 1; b_cnt = 0; b_base = a; b_ilv = ilv; b_wr = w;
  endtask

  task automatic t_adv(logic [LANES-1:0] lanes, string req);
    logic [1:0] lo;
    logic [1:0] c;
    logic [AW-1:0] a;
    @(negedge clk);
    clk_en = 1; adv = 1; sel = 1'($urandom); wr = 1'($urandom);
    addr = AW'($urandom); lane_we = lanes;
    if (b_act) begin
      b_cnt++;
      c = 2'(b_cnt);
      lo = b_ilv ? (b_base[1:0] ^ c) : (b_base[1:0] + c);
      a = {b_base[AW-1:2], lo};
      push_cmd(b_wr, a, lanes, req);
      if (b_cnt == 3) b_act = 0;
    end
  endtask

  task automatic t_desel();
    @(negedge clk);
    clk_en = 1; sel = 0; adv = 0; wr = 1; lane_we = '1;
    b_act = 0;
  endtask

  task automatic t_stall();
    @(negedge clk);
    clk_en = 0; adv = 1'($urandom); sel = 1; wr = 1'($urandom);
    addr = AW'($urandom); lane_we = '1;
  endtask

  // Enabled-edge counter and scoreboard retirement.
  always @(posedge clk) begin
    if (rst_n && clk_en) begin
      if (wq.size() > 0 && wq[0].due == n_en + 1) void'(wq.pop_front());
      if (rq.size() > 0 && rq[0].due == n_en + 1) void'(rq.pop_front());
      n_en++;
    end
  end

  // Bus driver for write data phases.
  always @(negedge clk) begin
    logic [63:0] r;
    r = {$urandom, $urandom};
    if (wq.size() > 0 && wq[0].due == n_en + 1) dq_i <= wq[0].data;
    else dq_i <= r[DW-1:0];
  end

  // Monitor: compares outputs in the middle of each cycle.
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (rq.size() > 0 && rq[0].due == n_en + 1) begin
        if (out_en) check(dq_drive === 1'b1 && dq_o === rq[0].data,
                          {rq[0].req, " R1 read word"}, dq_o, rq[0].data);
        else check(dq_drive === 1'b0, "R9 driver off with out_en low",
                   DW'(dq_drive), '0);
      end else begin
        check(dq_drive === 1'b0, "R9 no drive outside read phase", DW'(dq_drive), '0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check(dq_drive === 1'b0, "R11 reset drive", DW'(dq_drive), '0);

    // R2: fill every word with full-lane single writes, back to back
    for (int i = 0; i < DEPTH; i++) t_load(1, AW'(i), 4'hF, 0, "R2 fill");

    // R3: alternating traffic, reads at distance one and two after writes
    for (int i = 0; i < 24; i++) begin
      a = AW'($urandom);
      t_load(1, a, 4'($urandom), 0, "R3 write");
      t_load(0, a, '0, 0, "R3 read distance one");
      t_load(0, a, '0, 0, "R3 read distance two");
      t_load(0, AW'($urandom), '0, 0, "R3 other read");
    end

    // R2: partial lane write then read back
    t_load(1, 6'd5, 4'b0101, 0, "R2 lanes 0 and 2");
    t_load(1, 6'd5, 4'b1000, 0, "R2 lane 3");
    t_desel();
    t_load(0, 6'd5, '0, 0, "R2 partial readback");

    // R5: linear read burst from low bits 10 wraps 6,7,4,5
    t_load(0, 6'd6, '0, 0, "R5 linear beat0");
    for (int i = 0; i < 3; i++) t_adv('0, "R5 linear beat");
    // R5: linear write burst then readback burst
    t_load(1, 6'd13, 4'hF, 0, "R5 write beat0");
    for (int i = 0; i < 3; i++) t_adv(4'($urandom), "R5 write beat");
    t_load(0, 6'd12, '0, 0, "R5 readback beat0");
    for (int i = 0; i < 3; i++) t_adv('0, "R5 readback beat");

    // R6: interleaved write burst from low bits 01, read back linearly
    t_load(1, 6'd9, 4'hF, 1, "R6 ilv write beat0");
    for (int i = 0; i < 3; i++) t_adv(4'hF, "R6 ilv write beat");
    t_load(0, 6'd8, '0, 0, "R6 linear readback");
    for (int i = 0; i < 3; i++) t_adv('0, "R6 linear readback beat");
    t_load(0, 6'd11, '0, 1, "R6 ilv read beat0");
    for (int i = 0; i < 3; i++) t_adv('0, "R6 ilv read beat");

    // R7: stalls in the middle of read and write bursts
    t_load(0, 6'd20, '0, 0, "R7 read beat0");
    t_adv('0, "R7 read beat1");
    t_stall(); t_stall();
    t_adv('0, "R7 read beat2");
    t_stall();
    t_adv('0, "R7 read beat3");
    t_stall();
    t_load(1, 6'd30, 4'hF, 0, "R7 write beat0");
    t_stall();
    for (int i = 0; i < 3; i++) begin t_adv(4'hF, "R7 write beat"); t_stall(); end
    t_load(0, 6'd28, '0, 0, "R7 readback beat0");
    for (int i = 0; i < 3; i++) t_adv('0, "R7 readback beat");

    // R4 and R10: advance past the fourth beat and with no burst is a no-op
    t_load(1, 6'd40, 4'hF, 0, "R4 write beat0");
    for (int i = 0; i < 3; i++) t_adv(4'hF, "R4 write beat");
    t_adv(4'hF, "R10 extra advance");
    t_adv(4'hF, "R10 extra advance");
    t_load(0, 6'd40, '0, 0, "R10 readback");
    for (int i = 0; i < 3; i++) t_adv('0, "R10 readback beat");
    t_adv('0, "R10 nop after read burst");
    t_load(0, 6'd44, '0, 0, "R10 neighbour untouched");

    // R8: deselect ends an open write burst; later advance writes nothing
    t_load(1, 6'd48, 4'hF, 0, "R8 write beat0");
    t_adv(4'hF, "R8 write beat1");
    t_desel();
    t_adv(4'hF, "R8 advance after deselect");
    t_desel(); t_desel(); t_desel();
    t_load(0, 6'd48, '0, 0, "R8 readback");
    for (int i = 0; i < 3; i++) t_adv('0, "R8 readback beat");

    // R9: reads with drivers off, then a read with drivers on again
    t_load(0, 6'd3, '0, 0, "R9 off read");
    @(negedge clk); out_en = 0; clk_en = 1; sel = 1; adv = 0; wr = 0; addr = 6'd4;
    push_cmd(0, 6'd4, '0, "R9 off read"); b_act = 1; b_cnt = 0; b_base = 6'd4; b_ilv = 0; b_wr = 0;
    t_adv('0, "R9 off beat");
    t_desel(); t_desel();
    @(negedge clk); out_en = 1; clk_en = 1; sel = 0; adv = 0;
    t_load(0, 6'd4, '0, 0, "R9 on read");

    for (int i = 0; i < 4; i++) t_desel();
    @(negedge clk); #1;
    check(rq.size() == 0 && wq.size() == 0, "R8 pipeline drained",
          DW'(rq.size() + wq.size()), '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule